// File: doc/BRIEF.md
# Halt, Wake-up and Reset-Cause Sequencer

This block is the power-down sequencer of a small microcontroller core. A HALT request stops the system clock enable and clears the watchdog. The core then stays idle until one of four events wakes it: the external reset pin, a watchdog overflow, a newly raised interrupt request, or a falling edge on an enabled input-port bit. After a wake, the block holds the clock enable low for a fixed settling period. It then reports with a one-cycle strobe how execution resumes: at the next instruction, at the interrupt vector, or through a warm reset that clears only the program counter and stack pointer.

The block also keeps the two reset-cause flags, timeout (`flag_to`) and power-down (`flag_pdf`). It issues a full-reset strobe for the external reset pin, and for a watchdog overflow that occurs while the core is running.

The state machine has five states:
- RUN: the clock is enabled and the core executes.
- HALT: the clock is gated and the block waits for a wake source.
- SETTLE: the clock stays gated while the settling count runs.
- DONE: a one-cycle resume report.
- FULLRST: the full-reset strobe.

Transitions:
- RUN→HALT on an accepted HALT request.
- RUN/HALT/SETTLE/DONE/FULLRST→FULLRST on the reset pin.
- RUN→FULLRST on a watchdog overflow.
- HALT→SETTLE on any other wake source.
- SETTLE→DONE when the count ends.
- DONE→RUN and FULLRST→RUN when the reset pin is low.

Top module: `pwrdn_seq`

## Requirements
- R1: While `por_n` is low and in the first cycle after it rises, `clk_en`=1, `flag_to`=0, `flag_pdf`=0, and `full_rst`, `warm_rst` and `resume_valid` are 0.
- R2: In RUN, a `halt_req` with no `ext_rst_req` and no `wdt_ovf` in the same cycle does three things. It raises `wdt_clear` combinationally in that same cycle. From the next cycle it gives `clk_en`=0, `flag_pdf`=1 and `flag_to`=0.
- R3: In RUN, `wdt_clr` clears `flag_pdf` in the next cycle and leaves `flag_to` unchanged. A `halt_req` in the same cycle takes precedence over it.
- R4: `ext_rst_req` high in any state gives `full_rst`=1 and `clk_en`=1 in the next cycle. The flags are unchanged. Execution then returns to RUN.
- R5: A `wdt_ovf` in RUN gives a one-cycle `full_rst` in the next cycle, sets `flag_to`=1, and leaves `flag_pdf` unchanged.
- R6: A `wdt_ovf` in HALT sets `flag_to`=1 with `flag_pdf`=1 in the next cycle. After settling, it reports `resume_kind`=2 (warm reset) together with `warm_rst`=1.
- R7: In HALT, an interrupt request bit that was not already set at HALT entry wakes the device. `resume_kind` is 1 (vector) if a newly raised bit has its `irq_en` bit set and `stack_full` is 0 in the wake cycle. Otherwise `resume_kind` is 0 (next instruction).
- R8: An interrupt request bit that was already set when HALT was entered does not wake the device.
- R9: A falling edge, seen through a two-flop synchronizer, on a `port_in` bit whose `port_wake_en` bit is 1 wakes the device with `resume_kind`=0. A low level already present at HALT entry, a rising edge, or an edge on a disabled bit does not wake it.
- R10: Suppose a wake source is sampled at clock edge E. Then `clk_en` stays 0 through edge E+SETTLE_CYC. `resume_valid` and `clk_en` are 1 for the one cycle after edge E+SETTLE_CYC. A port edge adds the two synchronizer cycles before E.
- R11: Wake sources that arrive together are resolved in this order: `ext_rst_req`, then `wdt_ovf`, then interrupt, then port.
- R12: During SETTLE, `wdt_ovf`, interrupts and port edges have no effect on the flags or on the reported resume kind. Only `ext_rst_req` acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_req | input | 1 | External reset pin request, active high, synchronous |
| halt_req | input | 1 | HALT executed |
| wdt_clr | input | 1 | CLR WDT executed |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Interrupt enables |
| stack_full | input | 1 | Return stack is full |
| port_in | input | PORT_W | Input port pins |
| port_wake_en | input | PORT_W | Per-bit falling-edge wake enables |
| clk_en | output | 1 | System clock enable |
| wdt_clear | output | 1 | Clears watchdog counter and prescaler |
| resume_valid | output | 1 | One-cycle resume report |
| resume_kind | output | 2 | 0 next instruction, 1 interrupt vector, 2 warm reset |
| warm_rst | output | 1 | Clear program counter and stack pointer only |
| full_rst | output | 1 | Full device initialization |
| flag_to | output | 1 | Timeout flag |
| flag_pdf | output | 1 | Power-down flag |

## Verification
A wrong state register shows up at `clk_en` in the cycle after the faulty transition. A state that is stuck in HALT or SETTLE also shows up as a missing `resume_valid` at the exact edge where the settling count should end. A wrong latched wake cause is first visible on `resume_kind` and `warm_rst` in the single DONE cycle. A wrong flag update appears on `flag_to` or `flag_pdf` one cycle after the triggering strobe. A stale interrupt mask or a stale port sample appears either as a premature wake, which lowers the settling latency seen from the stimulus, or as `clk_en` staying low indefinitely.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_HALT    = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_DONE    = 3'd3,
        ST_FULLRST = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_NEXT   = 2'd0,
        RES_VECTOR = 2'd1,
        RES_WARM   = 2'd2
    } resume_kind_t;
endpackage

// File: rtl/port_fall_detect.sv
module port_fall_detect #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [PORT_W-1:0] pins,
    input  logic [PORT_W-1:0] wake_en,
    output logic              fall_any
);
    logic [PORT_W-1:0] sync1_q, sync2_q, prev_q;

    // Synchronizer and previous-sample register; pins idle high.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync1_q <= '1;
            sync2_q <= '1;
            prev_q  <= '1;
        end else begin
            sync1_q <= pins;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign fall_any = |(prev_q & ~sync2_q & wake_en);
endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter #(
    parameter int NIRQ = 4
) (
    input  logic                        wdt_ovf,
    input  logic [NIRQ-1:0]             irq_new,
    input  logic [NIRQ-1:0]             irq_en,
    input  logic                        stack_full,
    input  logic                        port_fall,
    output logic                        wake,
    output pwrdn_seq_pkg::resume_kind_t kind
);
    import pwrdn_seq_pkg::*;

    // Fixed priority below the reset pin: watchdog, interrupt, port.
    always_comb begin
        wake = wdt_ovf | (|irq_new) | port_fall;
        if (wdt_ovf)
            kind = RES_WARM;
        else if ((|irq_new) && (|(irq_new & irq_en)) && !stack_full)
            kind = RES_VECTOR;
        else
            kind = RES_NEXT;
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYC = 1024
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
    parameter int NIRQ       = 4,
    parameter int PORT_W     = 8,
    parameter int SETTLE_CYC = 1024
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_req,
    input  logic              halt_req,
    input  logic              wdt_clr,
    input  logic              wdt_ovf,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic [NIRQ-1:0]   irq_en,
    input  logic              stack_full,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_wake_en,
    output logic              clk_en,
    output logic              wdt_clear,
    output logic              resume_valid,
    output logic [1:0]        resume_kind,
    output logic              warm_rst,
    output logic              full_rst,
    output logic              flag_to,
    output logic              flag_pdf
);
    import pwrdn_seq_pkg::*;

    seq_state_t   state_q, state_d;
    resume_kind_t kind_q, arb_kind;
    logic [NIRQ-1:0] irq_mask_q;
    logic port_fall, arb_wake, settle_done, in_halt, halt_take;

    assign in_halt   = (state_q == ST_HALT);
    assign halt_take = (state_q == ST_RUN) && halt_req && !ext_rst_req && !wdt_ovf;

    port_fall_detect #(.PORT_W(PORT_W)) u_port (
        .clk      (clk),
        .por_n    (por_n),
        .pins     (port_in),
        .wake_en  (port_wake_en),
        .fall_any (port_fall)
    );

    wake_arbiter #(.NIRQ(NIRQ)) u_arb (
        .wdt_ovf    (wdt_ovf),
        .irq_new    (irq_req & ~irq_mask_q),
        .irq_en     (irq_en),
        .stack_full (stack_full),
        .port_fall  (port_fall),
        .wake       (arb_wake),
        .kind       (arb_kind)
    );

    settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .por_n (por_n),
        .run   (state_q == ST_SETTLE),
        .done  (settle_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ext_rst_req || wdt_ovf) state_d = ST_FULLRST;
                else if (halt_req)          state_d = ST_HALT;
            end
            ST_HALT: begin
                if (ext_rst_req)   state_d = ST_FULLRST;
                else if (arb_wake) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (ext_rst_req)      state_d = ST_FULLRST;
                else if (settle_done) state_d = ST_DONE;
            end
            ST_DONE:    state_d = ext_rst_req ? ST_FULLRST : ST_RUN;
            ST_FULLRST: state_d = ext_rst_req ? ST_FULLRST : ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Wake cause, interrupt mask and reset-cause flags
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            kind_q     <= RES_NEXT;
            irq_mask_q <= '0;
            flag_to    <= 1'b0;
            flag_pdf   <= 1'b0;
        end else begin
            if (halt_take) begin
                irq_mask_q <= irq_req;
                flag_pdf   <= 1'b1;
                flag_to    <= 1'b0;
            end else if (state_q == ST_RUN && !ext_rst_req) begin
                if (wdt_ovf)      flag_to  <= 1'b1;
                else if (wdt_clr) flag_pdf <= 1'b0;
            end
            if (in_halt && !ext_rst_req && arb_wake) begin
                kind_q <= arb_kind;
                if (wdt_ovf) flag_to <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        clk_en       = (state_q == ST_RUN) || (state_q == ST_DONE) || (state_q == ST_FULLRST);
        wdt_clear    = halt_take;
        resume_valid = (state_q == ST_DONE);
        resume_kind  = kind_q;
        warm_rst     = (state_q == ST_DONE) && (kind_q == RES_WARM);
        full_rst     = (state_q == ST_FULLRST);
    end
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
    parameter int SETTLE_CYC = 1024
) (
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_req,
    input logic       halt_req,
    input logic       wdt_clr,
    input logic       wdt_ovf,
    input logic       clk_en,
    input logic       resume_valid,
    input logic [1:0] resume_kind,
    input logic       warm_rst,
    input logic       full_rst,
    input logic       flag_to,
    input logic       flag_pdf,
    input logic [2:0] state_q
);
    import pwrdn_seq_pkg::*;

    localparam int CW = $clog2(SETTLE_CYC + 2) + 1;
    logic [CW-1:0] settle_seen;
    logic in_run;

    assign in_run = (state_q == ST_RUN);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                       settle_seen <= '0;
        else if (state_q == ST_SETTLE)    settle_seen <= settle_seen + 1'b1;
        else if (state_q != ST_DONE)      settle_seen <= '0;
    end

    p_halt_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
        (in_run && halt_req && !ext_rst_req && !wdt_ovf) |=> (!clk_en && flag_pdf && !flag_to));

    p_clr_pdf_r3: assert property (@(posedge clk) disable iff (!por_n)
        (in_run && wdt_clr && !halt_req && !ext_rst_req && !wdt_ovf) |=> !flag_pdf);

    p_ext_full_r4: assert property (@(posedge clk) disable iff (!por_n)
        ext_rst_req |=> (full_rst && clk_en && $stable(flag_to) && $stable(flag_pdf)));

    p_wdt_run_r5: assert property (@(posedge clk) disable iff (!por_n)
        (in_run && wdt_ovf && !ext_rst_req) |=> (full_rst && flag_to && $stable(flag_pdf)));

    p_warm_r6: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |-> (resume_valid && flag_to && flag_pdf && resume_kind == 2'd2));

    p_settle_len_r10: assert property (@(posedge clk) disable iff (!por_n)
        resume_valid |-> (clk_en && settle_seen == CW'(SETTLE_CYC)));

    p_settle_hold_r12: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_SETTLE && !ext_rst_req) |=> ((state_q == ST_SETTLE || state_q == ST_DONE) && $stable(flag_to)));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!por_n)
        !(full_rst && resume_valid));
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .ext_rst_req  (ext_rst_req),
    .halt_req     (halt_req),
    .wdt_clr      (wdt_clr),
    .wdt_ovf      (wdt_ovf),
    .clk_en       (clk_en),
    .resume_valid (resume_valid),
    .resume_kind  (resume_kind),
    .warm_rst     (warm_rst),
    .full_rst     (full_rst),
    .flag_to      (flag_to),
    .flag_pdf     (flag_pdf),
    .state_q      (state_q)
);

// File: tb/tb_pwrdn_seq.sv
module tb_pwrdn_seq;
    localparam int NIRQ = 2;
    localparam int PW   = 8;
    localparam int N    = 20;

    logic clk = 1'b0;
    logic por_n, ext_rst_req, halt_req, wdt_clr, wdt_ovf, stack_full;
    logic [NIRQ-1:0] irq_req, irq_en;
    logic [PW-1:0] port_in, port_wake_en;
    logic clk_en, wdt_clear, resume_valid, warm_rst, full_rst, flag_to, flag_pdf;
    logic [1:0] resume_kind;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    pwrdn_seq #(.NIRQ(NIRQ), .PORT_W(PW), .SETTLE_CYC(N)) dut (
        .clk(clk), .por_n(por_n), .ext_rst_req(ext_rst_req), .halt_req(halt_req),
        .wdt_clr(wdt_clr), .wdt_ovf(wdt_ovf), .irq_req(irq_req), .irq_en(irq_en),
        .stack_full(stack_full), .port_in(port_in), .port_wake_en(port_wake_en),
        .clk_en(clk_en), .wdt_clear(wdt_clear), .resume_valid(resume_valid),
        .resume_kind(resume_kind), .warm_rst(warm_rst), .full_rst(full_rst),
        .flag_to(flag_to), .flag_pdf(flag_pdf)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter_halt();
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
    endtask

    // Counts edges until resume_valid is seen, starting from 'start'.
    task automatic wait_resume(input int start, output int k);
        k = start;
        while (!resume_valid && k < 4 * N) begin
            tick();
            k++;
        end
    endtask

    task automatic t_reset();
        chk("R1 clk_en in reset", clk_en, 1);
        chk("R1 to in reset", flag_to, 0);
        chk("R1 pdf in reset", flag_pdf, 0);
        por_n = 1'b1;
        tick();
        chk("R1 strobes after reset", {full_rst, warm_rst, resume_valid}, 0);
        chk("R1 clk_en after reset", clk_en, 1);
    endtask

    task automatic t_halt_entry();
        halt_req = 1'b1;
        #0.1;
        chk("R2 wdt_clear same cycle", wdt_clear, 1);
        tick();
        halt_req = 1'b0;
        chk("R2 clk gated", clk_en, 0);
        chk("R2 pdf set", flag_pdf, 1);
        chk("R2 to clear", flag_to, 0);
        repeat (5) tick();
        chk("R2 stays halted", clk_en, 0);
    endtask

    task automatic t_irq_vector();
        int k;
        irq_en = 2'b11;
        stack_full = 1'b0;
        irq_req[1] = 1'b1;
        tick();
        wait_resume(1, k);
        chk("R10 irq latency", k, N + 1);
        chk("R7 vector kind", resume_kind, 1);
        chk("R10 clk_en at resume", clk_en, 1);
        tick();
        chk("R10 resume one cycle", resume_valid, 0);
        irq_req = '0;
    endtask

    task automatic t_irq_next(input logic full, input logic [NIRQ-1:0] en, input string tag);
        int k;
        irq_en = en;
        stack_full = full;
        enter_halt();
        irq_req[0] = 1'b1;
        tick();
        wait_resume(1, k);
        chk({"R7 next kind ", tag}, resume_kind, 0);
        tick();
        irq_req = '0;
        stack_full = 1'b0;
    endtask

    task automatic t_irq_pending();
        int k;
        irq_en = 2'b11;
        irq_req[0] = 1'b1;
        tick();
        enter_halt();
        repeat (10) tick();
        chk("R8 pending irq no wake", clk_en, 0);
        irq_req[1] = 1'b1;
        tick();
        wait_resume(1, k);
        chk("R8 new irq wakes", k, N + 1);
        tick();
        irq_req = '0;
    endtask

    task automatic t_port();
        int k;
        port_wake_en = 8'h0F;
        port_in = 8'hFD;
        repeat (3) tick();
        enter_halt();
        repeat (4) tick();
        chk("R9 low level no wake", clk_en, 0);
        port_in = 8'h7F;
        repeat (6) tick();
        chk("R9 rising or disabled no wake", clk_en, 0);
        port_in = 8'h7B;
        wait_resume(0, k);
        chk("R10 port latency", k, N + 3);
        chk("R9 port kind", resume_kind, 0);
        tick();
        port_in = 8'hFF;
        repeat (3) tick();
    endtask

    task automatic t_wdt_wake();
        int k;
        enter_halt();
        wdt_ovf = 1'b1;
        irq_en = 2'b11;
        irq_req[0] = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        chk("R6 to set", flag_to, 1);
        chk("R6 pdf set", flag_pdf, 1);
        chk("R6 clk gated", clk_en, 0);
        wait_resume(1, k);
        chk("R11 wdt over irq kind", resume_kind, 2);
        chk("R6 warm strobe", warm_rst, 1);
        chk("R6 no full", full_rst, 0);
        tick();
        irq_req = '0;
    endtask

    task automatic t_wdt_run();
        wdt_ovf = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        chk("R5 full strobe", full_rst, 1);
        chk("R5 to set", flag_to, 1);
        chk("R5 pdf unchanged", flag_pdf, 1);
        tick();
        chk("R5 single pulse", full_rst, 0);
    endtask

    task automatic t_ext_run();
        ext_rst_req = 1'b1;
        tick();
        ext_rst_req = 1'b0;
        chk("R4 full strobe run", full_rst, 1);
        chk("R4 clk_en", clk_en, 1);
        chk("R4 flags unchanged", {flag_to, flag_pdf}, 3);
        tick();
        chk("R4 back to run", {full_rst, clk_en}, 1);
    endtask

    task automatic t_clr();
        wdt_clr = 1'b1;
        tick();
        wdt_clr = 1'b0;
        chk("R3 pdf cleared", flag_pdf, 0);
        chk("R3 to unchanged", flag_to, 1);
        wdt_clr = 1'b1;
        enter_halt();
        wdt_clr = 1'b0;
        chk("R3 halt wins over clr", flag_pdf, 1);
    endtask

    task automatic t_ext_halt();
        ext_rst_req = 1'b1;
        wdt_ovf = 1'b1;
        tick();
        ext_rst_req = 1'b0;
        wdt_ovf = 1'b0;
        chk("R11 ext over wdt", full_rst, 1);
        chk("R4 flags out of halt", {flag_to, flag_pdf}, 1);
        tick();
    endtask

    task automatic t_settle_ignore();
        int k;
        irq_en = 2'b11;
        enter_halt();
        irq_req[1] = 1'b1;
        port_in = 8'h00;
        port_wake_en = 8'hFF;
        tick();
        repeat (3) tick();
        wdt_ovf = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        chk("R12 to untouched in settle", flag_to, 0);
        wait_resume(5, k);
        chk("R12 latency unchanged", k, N + 1);
        chk("R11 irq over port kind", resume_kind, 1);
        tick();
        irq_req = '0;
        port_in = 8'hFF;
        repeat (3) tick();
        enter_halt();
        irq_req[0] = 1'b1;
        tick();
        repeat (4) tick();
        ext_rst_req = 1'b1;
        tick();
        ext_rst_req = 1'b0;
        chk("R4 ext in settle", {full_rst, clk_en}, 3);
        tick();
        irq_req = '0;
    endtask

    initial begin
        por_n = 1'b0; ext_rst_req = 1'b0; halt_req = 1'b0; wdt_clr = 1'b0;
        wdt_ovf = 1'b0; stack_full = 1'b0; irq_req = '0; irq_en = '0;
        port_in = '1; port_wake_en = '0;
        repeat (3) tick();
        t_reset();
        t_halt_entry();
        t_irq_vector();
        t_irq_next(1'b1, 2'b11, "stack full");
        t_irq_next(1'b0, 2'b10, "disabled");
        t_irq_pending();
        t_port();
        t_wdt_run();
        t_ext_run();
        t_clr();
        t_ext_halt();
        t_wdt_wake();
        wdt_clr = 1'b1;
        tick();
        wdt_clr = 1'b0;
        ext_rst_req = 1'b1;
        tick();
        ext_rst_req = 1'b0;
        tick();
        t_settle_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule